// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement Unit

This block holds the replacement state for a set-associative cache whose way count is a power of two. Each set keeps a binary tree of `NUM_WAYS-1` bits. One port records that a way of a set was just used; a second, independent port names the way to evict from a set. Tag matching and line storage belong to the surrounding cache.

Each tree node points toward the half of its subtree that was used less recently. An access marks the node bits along its path so that they point away from the accessed way. A lookup follows the pointers from the root down to a leaf. A one-cycle clear empties the state of every set. With one way, the block keeps no state and always names way 0.

Top module: `plru_tree_unit`

## Requirements
- R1: After reset every set's victim is way 0.
- R2: With two or more ways, the cycle after an access to way w of set s, a lookup of set s never returns w, provided no clear occurred.
- R3: The tree bits are in heap order: node n has children 2n+1 and 2n+2, and the root is node 0. An access sets each node on the path to the inverse of the way bit decided at that node's depth. At the bottom level this is bit 0, and the bottom node is w/2 + (W-1)/2. After a single access to way w from the cleared state, the victim is way (1 - msb(w)) << (log2(W)-1).
- R4: A lookup starts at the root and takes the left child on bit 0 and the right child on bit 1. At the bottom node b it returns 2*(b - (W-1)/2), plus 1 if the bit of b is set.
- R5: Starting from a cleared set, accesses to ways 0, 1, ..., W-1 in order make way 0 the victim.
- R6: With a single way, the victim is always 0 and updates have no effect.
- R7: A clear zeroes every tree bit of every set at the next clock edge, so every set's victim is then way 0.
- R8: A clear takes priority over an update in the same cycle, and that update is lost.
- R9: The lookup is combinational from the stored state. An update takes effect at the next clock edge, so a lookup of the set being updated in the same cycle returns the victim from the state before the update.
- R10: An update to one set leaves the victim of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of all tree state |
| upd_valid_i | input | 1 | Record an access this cycle |
| upd_set_i | input | SET_W | Set of the recorded access |
| upd_way_i | input | WAY_W | Way of the recorded access |
| vic_set_i | input | SET_W | Set to look up |
| vic_way_o | output | WAY_W | Way to replace in `vic_set_i` |

## Verification
The bench runs an eight-way, four-set instance against a heap-walk model through a long pseudo-random mix of updates, lookups and clears, and drives a single-way instance in parallel. It sweeps every way with a single access from the cleared state. An inverted leaf or ancestor bit would show up there as a wrong victim half. A reversed walk direction would name the way just used. The bench also places updates and lookups of the same set in one cycle, where a lookup that bypasses the stored state would return the post-update victim. It applies clear together with an update, where a wrong priority leaves a non-zero victim. It also watches untouched sets for a decode that writes the wrong row.

// File: rtl/plru_pkg.sv
package plru_pkg;
  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/plru_path_update.sv
// Writes the access path of one tree: every node on the path gets the
// inverse of the way bit decided at its depth.
module plru_path_update #(
  parameter int WAYS = 4
) (
  input  logic [$clog2(WAYS)-1:0] way_i,
  input  logic [WAYS-2:0]         bits_i,
  output logic [WAYS-2:0]         bits_o
);
  localparam int LEVELS = $clog2(WAYS);

  for (genvar d = 0; d < LEVELS; d++) begin : g_lvl
    for (genvar k = 0; k < (1 << d); k++) begin : g_node
      localparam int NODE = (1 << d) - 1 + k;
      logic touch;
      assign touch = (way_i >> (LEVELS - d)) == LEVELS'(k);
      assign bits_o[NODE] = touch ? ~way_i[LEVELS-1-d] : bits_i[NODE];
    end
  end
endmodule

// File: rtl/plru_victim_walk.sv
// Root-to-leaf walk; the bit chosen at each level is the next way bit.
module plru_victim_walk #(
  parameter int WAYS = 4
) (
  input  logic [WAYS-2:0]         bits_i,
  output logic [$clog2(WAYS)-1:0] way_o
);
  localparam int LEVELS = $clog2(WAYS);

  for (genvar d = 0; d < LEVELS; d++) begin : g_lvl
    logic [(1<<d)-1:0] row;
    logic [d:0]        path;
    assign row = bits_i[(1<<d)-1 +: (1<<d)];
    if (d == 0) begin : g_root
      assign path = row[0];
    end else begin : g_inner
      assign path = {g_lvl[d-1].path, row[g_lvl[d-1].path]};
    end
  end

  assign way_o = g_lvl[LEVELS-1].path;
endmodule

// File: rtl/plru_state_array.sv
module plru_state_array #(
  parameter int SETS  = 8,
  parameter int NODES = 3,
  parameter int SET_W = plru_pkg::idx_width(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             wr_en_i,
  input  logic [SET_W-1:0] wr_set_i,
  input  logic [NODES-1:0] wr_bits_i,
  input  logic [SET_W-1:0] upd_set_i,
  output logic [NODES-1:0] upd_bits_o,
  input  logic [SET_W-1:0] vic_set_i,
  output logic [NODES-1:0] vic_bits_o
);
  logic [NODES-1:0] tree_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic hit;
    assign hit = wr_en_i && (wr_set_i == SET_W'(s));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      tree_q[s] <= '0;
      else if (clear_i) tree_q[s] <= '0;
      else if (hit)     tree_q[s] <= wr_bits_i;
    end
  end

  assign upd_bits_o = tree_q[upd_set_i];
  assign vic_bits_o = tree_q[vic_set_i];
endmodule

// File: rtl/plru_tree_unit.sv
module plru_tree_unit #(
  parameter int NUM_SETS = 8,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = plru_pkg::idx_width(NUM_SETS),
  localparam int WAY_W = plru_pkg::idx_width(NUM_WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             upd_valid_i,
  input  logic [SET_W-1:0] upd_set_i,
  input  logic [WAY_W-1:0] upd_way_i,
  input  logic [SET_W-1:0] vic_set_i,
  output logic [WAY_W-1:0] vic_way_o
);
  if (NUM_WAYS == 1) begin : g_direct
    logic unused_inputs;
    assign unused_inputs = ^{clk_i, rst_ni, clear_i, upd_valid_i,
                             upd_set_i, upd_way_i, vic_set_i};
    assign vic_way_o = '0;
  end else begin : g_tree
    localparam int NODES = NUM_WAYS - 1;
    logic [NODES-1:0] cur_bits, nxt_bits, vic_bits;

    plru_state_array #(
      .SETS (NUM_SETS),
      .NODES(NODES),
      .SET_W(SET_W)
    ) i_state (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clear_i   (clear_i),
      .wr_en_i   (upd_valid_i),
      .wr_set_i  (upd_set_i),
      .wr_bits_i (nxt_bits),
      .upd_set_i (upd_set_i),
      .upd_bits_o(cur_bits),
      .vic_set_i (vic_set_i),
      .vic_bits_o(vic_bits)
    );

    plru_path_update #(.WAYS(NUM_WAYS)) i_update (
      .way_i (upd_way_i),
      .bits_i(cur_bits),
      .bits_o(nxt_bits)
    );

    plru_victim_walk #(.WAYS(NUM_WAYS)) i_walk (
      .bits_i(vic_bits),
      .way_o (vic_way_o)
    );
  end
endmodule

// File: rtl/plru_tree_unit_chk.sv
module plru_tree_unit_chk #(
  parameter int NUM_SETS = 8,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = plru_pkg::idx_width(NUM_SETS),
  localparam int WAY_W = plru_pkg::idx_width(NUM_WAYS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             upd_valid_i,
  input logic [SET_W-1:0] upd_set_i,
  input logic [WAY_W-1:0] upd_way_i,
  input logic [SET_W-1:0] vic_set_i,
  input logic [WAY_W-1:0] vic_way_o
);
  if (NUM_WAYS > 1) begin : g_multi
    // R2
    a_r2_not_just_used: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(upd_valid_i) && !$past(clear_i) && vic_set_i == $past(upd_set_i))
      |-> vic_way_o != $past(upd_way_i));
  end else begin : g_single
    // R6
    a_r6_single_way: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vic_way_o == '0);
  end

  // R7
  a_r7_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> vic_way_o == '0);

  // R8
  a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && upd_valid_i) |=> vic_way_o == '0);

  // R9, R10
  a_r9_hold_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vic_set_i == $past(vic_set_i) && !$past(clear_i) &&
     !($past(upd_valid_i) && $past(upd_set_i) == vic_set_i))
    |-> $stable(vic_way_o));
endmodule

bind plru_tree_unit plru_tree_unit_chk #(
  .NUM_SETS(NUM_SETS),
  .NUM_WAYS(NUM_WAYS)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clear_i    (clear_i),
  .upd_valid_i(upd_valid_i),
  .upd_set_i  (upd_set_i),
  .upd_way_i  (upd_way_i),
  .vic_set_i  (vic_set_i),
  .vic_way_o  (vic_way_o)
);

// File: tb/test_plru_tree_unit.sv
`timescale 1ns/1ps
module test_plru_tree_unit;
  localparam int SETS = 4;
  localparam int WAYS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       uv = 1'b0;
  logic [1:0] us = '0;
  logic [2:0] uw = '0;
  logic [1:0] vs = '0;
  logic [2:0] vw;
  logic       vw1;

  int checks = 0;
  int errors = 0;
  logic [6:0] model [SETS];

  always #5 clk = ~clk;

  plru_tree_unit #(.NUM_SETS(SETS), .NUM_WAYS(WAYS)) i_plru_tree_unit (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clr), .upd_valid_i(uv),
    .upd_set_i(us), .upd_way_i(uw), .vic_set_i(vs), .vic_way_o(vw)
  );

  plru_tree_unit #(.NUM_SETS(SETS), .NUM_WAYS(1)) i_plru_tree_unit_w1 (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clr), .upd_valid_i(uv),
    .upd_set_i(us), .upd_way_i(uw[0]), .vic_set_i(vs), .vic_way_o(vw1)
  );

  // Heap-index model: leaf w/2+3, then climb with parity of child index.
  function automatic logic [6:0] m_touch(logic [6:0] t, int w);
    int idx;
    idx = w / 2 + 3;
    t[idx] = (w % 2 == 0);
    while (idx > 0) begin
      int par;
      par = (idx - 1) / 2;
      t[par] = (idx % 2 == 1);
      idx = par;
    end
    return t;
  endfunction

  function automatic int m_victim(logic [6:0] t);
    int idx;
    idx = 0;
    while (idx < 3) idx = t[idx] ? 2 * idx + 2 : 2 * idx + 1;
    return (idx - 3) * 2 + (t[idx] ? 1 : 0);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Drives one cycle from a negedge, checks the lookup before the edge
  // against the pre-update model, then advances the model.
  task automatic cyc(bit c, bit v, int s, int w, int ls, string req);
    clr = c; uv = v; us = 2'(s); uw = 3'(w); vs = 2'(ls);
    #1;
    check(req, int'(vw), m_victim(model[ls]));
    check("R6", int'(vw1), 0);
    @(posedge clk);
    if (c) begin
      for (int i = 0; i < SETS; i++) model[i] = '0;
    end else if (v) model[s] = m_touch(model[s], w);
    @(negedge clk);
  endtask

  task automatic look_all(string req, int exp_each);
    for (int s = 0; s < SETS; s++) begin
      vs = 2'(s); uv = 1'b0; clr = 1'b0;
      #1;
      check(req, int'(vw), exp_each);
      check("R6", int'(vw1), 0);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    int last_set, last_way;
    bit last_v;
    for (int i = 0; i < SETS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    look_all("R1", 0);

    // R3: single access from the cleared state, every way
    for (int w = 0; w < WAYS; w++) begin
      cyc(1, 0, 0, 0, 0, "R7");
      cyc(0, 1, 1, w, 1, "R9");
      vs = 2'd1; #1;
      check("R3", int'(vw), ((w >> 2) & 1) ? 0 : 4);
      vs = 2'd0; #1;
      check("R10", int'(vw), 0);
    end

    // R5: ordered sweep of all ways
    cyc(1, 0, 0, 0, 0, "R7");
    for (int w = 0; w < WAYS; w++) cyc(0, 1, 2, w, 3, "R10");
    vs = 2'd2; #1;
    check("R5", int'(vw), 0);
    check("R4", int'(vw), m_victim(model[2]));

    // R9: same-set update and lookup in one cycle sees old state
    cyc(0, 1, 2, 0, 2, "R9");
    vs = 2'd2; #1;
    check("R2", int'(vw) == 0 ? 1 : 0, 0);

    // R2/R4/R10: pseudo-random traffic
    lfsr = 16'hACE1;
    last_v = 0; last_set = 0; last_way = 0;
    for (int n = 0; n < 4000; n++) begin
      bit c, v;
      int s, w, ls;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      c  = (lfsr[15:10] == 6'h3F);
      v  = lfsr[0] | lfsr[1];
      s  = int'(lfsr[3:2]);
      w  = int'(lfsr[6:4]);
      ls = lfsr[7] ? last_set : int'(lfsr[9:8]);
      if (last_v && ls == last_set) begin
        clr = c; uv = v; us = 2'(s); uw = 3'(w); vs = 2'(ls); #1;
        check("R2", int'(vw) == last_way ? 1 : 0, 0);
      end
      cyc(c, v, s, w, ls, "R4");
      last_v = v && !c; last_set = s; last_way = w;
    end

    // R8: clear with concurrent update
    cyc(0, 1, 0, 0, 0, "R4");
    cyc(1, 1, 0, 5, 0, "R4");
    look_all("R8", 0);

    // R7: clear after traffic on all sets
    for (int s = 0; s < SETS; s++) cyc(0, 1, s, 2 * s + 1, s, "R4");
    cyc(1, 0, 0, 0, 0, "R4");
    look_all("R7", 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule